// File: doc/BRIEF.md
# Outbound Virtual Wire Change Tracker

This block holds the outbound virtual wires that a device reports to its host. The wires are split into eleven groups of four. Firmware sets the wire levels and configures each group through a simple register port. For every wire the block keeps a read-only flag that records whether its level has moved since the host last collected it.

A priority scanner picks the lowest-numbered group that has pending changes and a legal host index. It presents that group's index, a per-wire valid mask and the current wire levels on a valid/ready transmit interface. When the transmitter accepts, only the flags that were presented are cleared. Each group also follows one of four external reset lines. When its chosen line is released, the group reloads a programmed pattern and flags every wire that this reload actually moved.

Top module: `vw_out_tracker`

## Requirements
- R1: After `rst_ni` is released, every configuration word, state word and change flag reads zero, and `tx_valid_o` is low.
- R2: With `reg_sel_i`=0 the configuration word of a group is accessed. Its fields are: bits 7:0 host index, bits 9:8 reset-line select, bits 15:12 reload pattern (bit n for wire n), bits 19:16 change flags (bit 16+n for wire n), and all other bits zero. With `reg_sel_i`=1 the state word is accessed, in which wire n sits at bit 8n. Writes keep only those wire bits and the other bits read back as zero.
- R3: A state write sets the change flag of each wire whose level differs from its previous value. A wire written with its existing level keeps its flag unchanged. No flag changes without a write, a reload or an accepted transmit.
- R4: A write to a configuration word leaves bits 19:16 (the change flags) unaffected.
- R5: `tx_valid_o` is high exactly when some group has a nonzero change flag set and a host index of at least 2. The group presented is the lowest-numbered one that qualifies.
- R6: While valid, `tx_index_o` is that group's host index, `tx_mask_o` is its change flags and `tx_data_o` is its four wire levels, with wire n at bit n.
- R7: While `tx_valid_o` is high and `tx_ready_i` is low, the presented outputs hold as long as there is no write and no reload.
- R8: On a cycle in which valid and ready are both high, the presented flags of that group are cleared. A wire change that lands in the same cycle leaves its flag set.
- R9: Select code s in 0..3 ties a group to `rst_line_ni[s]`. The cycle after that line is seen rising, the group's wires take the reload pattern. A rising edge on any other line has no effect on the group.
- R10: A reload sets the change flag only for wires whose level it actually changed.
- R11: When a reload and a state write hit the same group in the same cycle, the reload wins.
- R12: Accesses with `reg_grp_i` of 11 or more write nothing and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the configuration word, 1 selects the state word |
| reg_grp_i | input | 4 | Group number to access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed word (combinational) |
| rst_line_ni | input | 4 | Synchronous active-low reset lines; release (rising edge) triggers a reload |
| tx_valid_o | output | 1 | A group has changes to send |
| tx_ready_i | input | 1 | Transmitter accepts the presented group |
| tx_index_o | output | 8 | Host index of the presented group |
| tx_mask_o | output | 4 | Change flags of the presented group |
| tx_data_o | output | 4 | Wire levels of the presented group |

## Verification
The assertions check on every cycle that a presented group is legal with a nonzero mask, that a stalled transfer holds steady, that accepted flags drop unless a new event arrives, and that the flags stay still when no write, reload or acceptance happens, including under configuration writes. Field layout, lowest-group priority with illegal indexes skipped, the choice of reset line, reloads onto identical levels, and the ordering of a reload against a write or an accept in the same cycle can only be shown by the bench scenarios. The bench compares every group's readback and the transmit outputs against a model after each step.

// File: rtl/vw_out_pkg.sv
package vw_out_pkg;
  localparam int unsigned WIRES        = 4;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned IDX_LSB      = 0;
  localparam int unsigned SRC_LSB      = 8;
  localparam int unsigned PAT_LSB      = 12;
  localparam int unsigned CHG_LSB      = 16;
  localparam int unsigned STATE_STRIDE = 8;

  typedef enum logic {
    SEL_CFG   = 1'b0,
    SEL_STATE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/vw_out_group.sv
module vw_out_group
  import vw_out_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned NSRC  = 4,
  localparam int unsigned SRC_W = $clog2(NSRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              st_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   src_rise_i,
  input  logic              ack_i,
  input  logic [WIRES-1:0]  ack_mask_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [WIRES-1:0]  pat_o,
  output logic [WIRES-1:0]  state_o,
  output logic [WIRES-1:0]  chg_o
);
  logic [WIRES-1:0] wr_st, nxt_st, nxt_chg, clr;
  logic             reload;

  assign reload = src_rise_i[src_o];

  always_comb begin
    for (int w = 0; w < WIRES; w++) wr_st[w] = wdata_i[w*STATE_STRIDE];
    // reload outranks a same-cycle firmware write
    nxt_st  = reload ? pat_o : (st_we_i ? wr_st : state_o);
    clr     = ack_i ? ack_mask_i : '0;
    nxt_chg = (chg_o & ~clr) | (nxt_st ^ state_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o   <= '0;
      src_o   <= '0;
      pat_o   <= '0;
      state_o <= '0;
      chg_o   <= '0;
    end else begin
      if (cfg_we_i) begin
        idx_o <= wdata_i[IDX_LSB +: IDX_W];
        src_o <= wdata_i[SRC_LSB +: SRC_W];
        pat_o <= wdata_i[PAT_LSB +: WIRES];
      end
      state_o <= nxt_st;
      chg_o   <= nxt_chg;
    end
  end
endmodule

// File: rtl/vw_out_scan.sv
module vw_out_scan
  import vw_out_pkg::*;
#(
  parameter int unsigned NUM_GRP = 11,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned MIN_IDX = 2,
  localparam int unsigned GRP_W  = $clog2(NUM_GRP)
) (
  input  logic [NUM_GRP-1:0][WIRES-1:0] grp_chg_i,
  input  logic [NUM_GRP-1:0][IDX_W-1:0] grp_idx_i,
  output logic                          valid_o,
  output logic [GRP_W-1:0]              sel_o
);
  always_comb begin
    valid_o = 1'b0;
    sel_o   = '0;
    // descend so the lowest qualifying group is the last to win
    for (int g = NUM_GRP - 1; g >= 0; g--) begin
      if ((|grp_chg_i[g]) && (grp_idx_i[g] >= IDX_W'(MIN_IDX))) begin
        valid_o = 1'b1;
        sel_o   = GRP_W'(g);
      end
    end
  end
endmodule

// File: rtl/vw_out_tracker.sv
module vw_out_tracker
  import vw_out_pkg::*;
#(
  parameter int unsigned NUM_GRP = 11,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned MIN_IDX = 2,
  parameter int unsigned NSRC    = 4,
  localparam int unsigned GRP_W  = $clog2(NUM_GRP),
  localparam int unsigned SRC_W  = $clog2(NSRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [GRP_W-1:0]  reg_grp_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  input  logic [NSRC-1:0]   rst_line_ni,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [IDX_W-1:0]  tx_index_o,
  output logic [WIRES-1:0]  tx_mask_o,
  output logic [WIRES-1:0]  tx_data_o
);
  logic [NSRC-1:0]                dom_q, dom_rise;
  logic [NUM_GRP-1:0][IDX_W-1:0]  grp_idx;
  logic [NUM_GRP-1:0][SRC_W-1:0]  grp_src;
  logic [NUM_GRP-1:0][WIRES-1:0]  grp_pat, grp_st, grp_chg;
  logic [GRP_W-1:0]               sel_grp;
  logic                           scan_valid, accept;

  // release of an active-low line is its rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dom_q <= '1;
    else         dom_q <= rst_line_ni;
  end
  assign dom_rise = rst_line_ni & ~dom_q;

  assign accept = scan_valid && tx_ready_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic hit;
    assign hit = reg_we_i && (reg_grp_i == GRP_W'(g));
    vw_out_group #(.IDX_W(IDX_W), .NSRC(NSRC)) i_grp (
      .clk_i,
      .rst_ni,
      .cfg_we_i   (hit && (reg_sel_i == SEL_CFG)),
      .st_we_i    (hit && (reg_sel_i == SEL_STATE)),
      .wdata_i    (reg_wdata_i),
      .src_rise_i (dom_rise),
      .ack_i      (accept && (sel_grp == GRP_W'(g))),
      .ack_mask_i (grp_chg[g]),
      .idx_o      (grp_idx[g]),
      .src_o      (grp_src[g]),
      .pat_o      (grp_pat[g]),
      .state_o    (grp_st[g]),
      .chg_o      (grp_chg[g])
    );
  end

  vw_out_scan #(.NUM_GRP(NUM_GRP), .IDX_W(IDX_W), .MIN_IDX(MIN_IDX)) i_scan (
    .grp_chg_i (grp_chg),
    .grp_idx_i (grp_idx),
    .valid_o   (scan_valid),
    .sel_o     (sel_grp)
  );

  assign tx_valid_o = scan_valid;
  assign tx_index_o = scan_valid ? grp_idx[sel_grp] : '0;
  assign tx_mask_o  = scan_valid ? grp_chg[sel_grp] : '0;
  assign tx_data_o  = scan_valid ? grp_st[sel_grp]  : '0;

  always_comb begin
    reg_rdata_o = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (reg_grp_i == GRP_W'(g)) begin
        if (reg_sel_i == SEL_STATE) begin
          for (int w = 0; w < WIRES; w++) reg_rdata_o[w*STATE_STRIDE] = grp_st[g][w];
        end else begin
          reg_rdata_o[IDX_LSB +: IDX_W] = grp_idx[g];
          reg_rdata_o[SRC_LSB +: SRC_W] = grp_src[g];
          reg_rdata_o[PAT_LSB +: WIRES] = grp_pat[g];
          reg_rdata_o[CHG_LSB +: WIRES] = grp_chg[g];
        end
      end
    end
  end
endmodule

// File: rtl/vw_out_tracker_chk.sv
module vw_out_tracker_chk
  import vw_out_pkg::*;
#(
  parameter int unsigned NUM_GRP = 11,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned MIN_IDX = 2,
  parameter int unsigned NSRC    = 4,
  localparam int unsigned GRP_W  = $clog2(NUM_GRP)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          reg_we_i,
  input logic                          reg_sel_i,
  input logic                          tx_valid_o,
  input logic                          tx_ready_i,
  input logic [IDX_W-1:0]              tx_index_o,
  input logic [WIRES-1:0]              tx_mask_o,
  input logic [WIRES-1:0]              tx_data_o,
  input logic [NUM_GRP-1:0][WIRES-1:0] grp_chg,
  input logic [GRP_W-1:0]              sel_grp,
  input logic [NSRC-1:0]               dom_rise
);
  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_idle_R1: assert (!tx_valid_o && grp_chg == '0);
  end

  assert_valid_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (tx_mask_o != '0) && (tx_index_o >= IDX_W'(MIN_IDX)));

  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i && !reg_we_i && (dom_rise == '0)
    |=> tx_valid_o && $stable(tx_index_o) && $stable(tx_mask_o) && $stable(tx_data_o));

  assert_ack_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && !reg_we_i && (dom_rise == '0)
    |=> (grp_chg[$past(sel_grp)] & $past(tx_mask_o)) == '0);

  assert_flags_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i && (dom_rise == '0) && !(tx_valid_o && tx_ready_i) |=> $stable(grp_chg));

  assert_cfg_no_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && (reg_sel_i == SEL_CFG) && (dom_rise == '0) && !(tx_valid_o && tx_ready_i)
    |=> $stable(grp_chg));
endmodule

bind vw_out_tracker vw_out_tracker_chk #(
  .NUM_GRP(NUM_GRP), .IDX_W(IDX_W), .MIN_IDX(MIN_IDX), .NSRC(NSRC)
) i_chk (.*);

// File: tb/test_vw_out_tracker.sv
`timescale 1ns/100ps
module test_vw_out_tracker;
  localparam int NG = 11;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0, reg_sel = 0;
  logic [3:0]  reg_grp = 0;
  logic [31:0] reg_wd = 0, reg_rd;
  logic [3:0]  dom = 4'hF;
  logic        tx_valid, tx_ready = 0;
  logic [7:0]  tx_index;
  logic [3:0]  tx_mask, tx_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_idx [NG];
  logic [1:0] m_src [NG];
  logic [3:0] m_pat [NG], m_st [NG], m_chg [NG];
  logic [3:0] m_dom = 4'hF;

  always #2.5 clk = ~clk;

  vw_out_tracker i_vw_out_tracker (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_grp_i(reg_grp), .reg_wdata_i(reg_wd), .reg_rdata_o(reg_rd),
    .rst_line_ni(dom), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .tx_index_o(tx_index), .tx_mask_o(tx_mask), .tx_data_o(tx_data)
  );

  function automatic logic [31:0] expand(input logic [3:0] p);
    logic [31:0] r = '0;
    for (int w = 0; w < 4; w++) r[w*8] = p[w];
    return r;
  endfunction

  function automatic logic [31:0] cfgw(input int idx, input int src, input logic [3:0] pat);
    return 32'(idx & 8'hFF) | (32'(src & 3) << 8) | (32'(pat) << 12);
  endfunction

  function automatic int exp_sel();
    for (int g = 0; g < NG; g++)
      if (m_chg[g] != 0 && m_idx[g] >= 2) return g;
    return -1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic sel, input int grp, input logic [31:0] wd,
                      input logic [3:0] d, input logic rdy);
    int sg = exp_sel();
    logic [3:0] rise = d & ~m_dom;
    logic [3:0] ns;
    reg_we = we; reg_sel = sel; reg_grp = 4'(grp); reg_wd = wd; dom = d; tx_ready = rdy;
    @(posedge clk); #1;
    reg_we = 0; tx_ready = 0;
    for (int g = 0; g < NG; g++) begin
      ns = m_st[g];
      if (rise[m_src[g]]) ns = m_pat[g];
      else if (we && sel && grp == g) for (int w = 0; w < 4; w++) ns[w] = wd[w*8];
      if (rdy && sg == g) m_chg[g] = 4'b0;
      m_chg[g] = m_chg[g] | (ns ^ m_st[g]);
      m_st[g] = ns;
    end
    if (we && !sel && grp < NG) begin
      m_idx[grp] = wd[7:0]; m_src[grp] = wd[9:8]; m_pat[grp] = wd[15:12];
    end
    m_dom = d;
  endtask

  task automatic check_all(input string req);
    int sg;
    for (int g = 0; g < NG; g++) begin
      reg_grp = 4'(g); reg_sel = 0; #0.5;
      chk(req, reg_rd, 32'(m_idx[g]) | (32'(m_src[g]) << 8) | (32'(m_pat[g]) << 12) | (32'(m_chg[g]) << 16));
      reg_sel = 1; #0.5;
      chk(req, reg_rd, expand(m_st[g]));
    end
    sg = exp_sel();
    if (sg < 0) chk(req, {31'b0, tx_valid}, 32'd0);
    else chk(req, {11'b0, tx_valid, tx_index, 4'b0, tx_mask, 4'b0, tx_data},
             {11'b0, 1'b1, m_idx[sg], 4'b0, m_chg[sg], 4'b0, m_st[sg]});
    @(posedge clk); #1;
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < NG + 1; k++) begin
      step(0, 0, 0, 0, m_dom, 1);
      check_all(req);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    for (int g = 0; g < NG; g++) begin
      m_idx[g] = 0; m_src[g] = 0; m_pat[g] = 0; m_st[g] = 0; m_chg[g] = 0;
    end
    #12 rst_n = 1;
    @(posedge clk); #1;
    check_all("R1");

    // R2 and R4: configure every group, attempting to set the flag bits too
    for (int g = 0; g < NG; g++)
      step(1, 0, g, cfgw(g + 2, g % 4, 4'(g * 3 + 1)) | 32'h000F_0000, m_dom, 0);
    check_all("R2");
    for (int g = 0; g < NG; g++)
      step(1, 1, g, expand(4'(g + 1)) | 32'hFEFE_FEFE, m_dom, 0);
    check_all("R2");

    // R6 and R8: send every pending group in order
    drain("R6");

    // R3: same-value write, then a single-wire change
    step(1, 1, 3, expand(m_st[3]), m_dom, 0);
    check_all("R3");
    step(1, 1, 3, expand(m_st[3] ^ 4'b0100), m_dom, 0);
    check_all("R3");

    // R4: configuration write with flag bits cleared does not clear flags
    step(1, 0, 3, cfgw(5, 3, m_pat[3]), m_dom, 0);
    check_all("R4");

    // R7: stall with ready low
    for (int k = 0; k < 3; k++) begin
      step(0, 0, 0, 0, m_dom, 0);
      check_all("R7");
    end

    // R5: group 0 with illegal index is skipped until made legal
    step(1, 0, 0, cfgw(1, 0, m_pat[0]), m_dom, 0);
    step(1, 1, 0, expand(~m_st[0]), m_dom, 0);
    check_all("R5");
    step(1, 0, 0, cfgw(2, 0, m_pat[0]), m_dom, 0);
    check_all("R5");

    // R8: accept group 0 while wire 0 changes again in the same cycle
    step(1, 1, 0, expand(m_st[0] ^ 4'b0001), m_dom, 1);
    check_all("R8");
    drain("R8");

    // R9: each reset-line code drives group 5; other lines leave it alone
    for (int s = 0; s < 4; s++) begin
      step(1, 0, 5, cfgw(7, s, 4'b1010 ^ 4'(s)), m_dom, 0);
      step(1, 1, 5, expand(4'b0101 ^ 4'(s)), m_dom, 0);
      step(0, 0, 0, 0, m_dom & ~(4'b1 << s), 0);
      step(0, 0, 0, 0, 4'hF, 0);
      check_all("R9");
      drain("R9");
      step(1, 1, 5, expand(4'b0000), m_dom, 0);
      step(0, 0, 0, 0, m_dom & ~(4'b1 << ((s + 1) % 4)), 0);
      step(0, 0, 0, 0, 4'hF, 0);
      check_all("R9");
      drain("R9");
    end

    // R10: reload onto levels that already match the pattern
    step(1, 1, 5, expand(m_pat[5]), m_dom, 0);
    drain("R10");
    step(0, 0, 0, 0, m_dom & ~(4'b1 << m_src[5]), 0);
    step(0, 0, 0, 0, 4'hF, 0);
    check_all("R10");
    drain("R10");

    // R11: reload and write to group 6 in one cycle
    step(0, 0, 0, 0, m_dom & ~(4'b1 << m_src[6]), 0);
    step(1, 1, 6, expand(~m_pat[6]), 4'hF, 0);
    check_all("R11");
    drain("R11");

    // R12: out-of-range group numbers
    step(1, 1, 12, 32'hFFFF_FFFF, m_dom, 0);
    step(1, 0, 11, 32'h0000_F3FF, m_dom, 0);
    check_all("R12");
    for (int g = 11; g < 16; g++) begin
      reg_grp = 4'(g); reg_sel = 0; #0.5;
      chk("R12", reg_rd, 32'h0);
      reg_sel = 1; #0.5;
      chk("R12", reg_rd, 32'h0);
    end

    finish_run();
  end
endmodule